// File: doc/BRIEF.md
# Split Cache Control Register and Set-Index Generator

This block holds the control word for a split cache: one instruction cache and one operand cache. Software writes the word through a simple register port. The word enables each cache, picks how each cache forms its set index, selects the write policy, sets up RAM mode for the operand cache and holds a capacity-mode bit. Two bits in the word do not hold a value. Writing 1 to either of them starts a flash invalidate of one cache.

From an effective address the block forms both set indices. Each index is either a straight slice of the line-address bits, or the same slice with its top bit replaced by address bit 25. The block also keeps the per-entry valid flags of both caches and the usage flags of the operand cache. It sets those flags on fill and touch strobes from the cache datapath and reports them for the entry that the current address selects. A page-cacheable input and an address-translation-active input decide whether the instruction cache may actually be used.

Top module: `cachectl_top`

## Requirements
- R1: After reset every control bit is 0. Readback is 0, `ic_usable`, `oc_ram_act`, `copy_back`, `dbl_size` and `proto_err` are 0, and all flags are clear.
- R2: With the instruction index mode bit at 0, `ic_idx` = `ea[12:5]`. With it at 1, `ic_idx` = {`ea[25]`, `ea[11:5]`}.
- R3: With the operand index mode bit at 0, `oc_idx` = `ea[13:5]`. With it at 1, `oc_idx` = {`ea[25]`, `ea[12:5]`}.
- R4: A write with bit 1 set clears the valid flag of every instruction-cache entry. A lookup on the next cycle sees the flags cleared. Operand flags are not touched. Bit 1 always reads 0.
- R5: A write with bit 4 set clears the valid and usage flags of every operand-cache entry. A lookup on the next cycle sees them cleared. Bit 4 always reads 0.
- R6: `ic_usable` is 1 exactly when the instruction enable (bit 0) is 1 and either `xlat_on` is 0 or `page_cacheable` is 1.
- R7: `oc_ram_act` is 1 exactly when the operand enable (bit 3) and the RAM-mode bit (bit 6) are both 1.
- R8: `copy_back` follows bit 7: 0 selects write-through and 1 selects copy-back.
- R9: A write that would change the capacity-mode bit (bit 8) while either enable is currently 1 leaves that bit unchanged. The other bits of that write still take effect, and `proto_err` is 1 for the one cycle after that write. Writes that do not change bit 8, or that arrive while both caches are disabled, never raise `proto_err`.
- R10: A fill strobe sets the valid flag and a touch strobe sets the usage flag at the given index; the flag is visible on the next cycle. When a flash invalidate and a fill of the same cache fall in the same cycle, the invalidate wins.
- R11: The readback word has this layout: bit 0 instruction enable, bit 2 instruction index mode, bit 3 operand enable, bit 5 operand index mode, bit 6 RAM mode, bit 7 copy-back, bit 8 capacity mode. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register readback |
| ea | input | 32 | Effective address for lookup |
| xlat_on | input | 1 | Address translation active |
| page_cacheable | input | 1 | Cacheable flag of the current page |
| ic_fill | input | 1 | Set the instruction valid flag at `ic_fill_idx` |
| ic_fill_idx | input | 8 | Instruction entry to mark valid |
| oc_fill | input | 1 | Set the operand valid flag at `oc_fill_idx` |
| oc_fill_idx | input | 9 | Operand entry to mark valid |
| oc_touch | input | 1 | Set the operand usage flag at `oc_touch_idx` |
| oc_touch_idx | input | 9 | Operand entry to mark used |
| ic_idx | output | 8 | Instruction-cache set index |
| oc_idx | output | 9 | Operand-cache set index |
| ic_valid | output | 1 | Valid flag at `ic_idx` |
| oc_valid | output | 1 | Valid flag at `oc_idx` |
| oc_used | output | 1 | Usage flag at `oc_idx` |
| ic_usable | output | 1 | Instruction cache may be used for this access |
| oc_ram_act | output | 1 | Half of the operand cache serves as RAM |
| copy_back | output | 1 | Write policy: 1 copy-back, 0 write-through |
| dbl_size | output | 1 | Capacity mode bit |
| proto_err | output | 1 | One-cycle pulse on a blocked capacity-mode change |

## Verification
The assertions assume that `reg_wr` and the fill and touch strobes are clean 0/1 values that change only between clock edges. They also assume that software clears the RAM-mode bit whenever it clears the operand enable. The bench drives every input on the falling edge. Its only write with RAM mode set and the operand cache off comes from a deliberate check, and the RAM-mode check does not depend on that write. The capacity-bit checks first turn on both enables, then try to clear bit 8, so the blocked path is hit on purpose and not by accident.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;
  localparam int REG_W    = 16;
  localparam int B_IC_EN  = 0;
  localparam int B_IC_INV = 1;
  localparam int B_IC_HI  = 2;
  localparam int B_OC_EN  = 3;
  localparam int B_OC_INV = 4;
  localparam int B_OC_HI  = 5;
  localparam int B_OC_RAM = 6;
  localparam int B_CB     = 7;
  localparam int B_DBL    = 8;

  typedef struct packed {
    logic dbl;
    logic cb;
    logic oc_ram;
    logic oc_hi;
    logic oc_en;
    logic ic_hi;
    logic ic_en;
  } ctl_t;
endpackage

// File: rtl/cachectl_rstsync.sv
module cachectl_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/cachectl_regs.sv
module cachectl_regs
  import cachectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ctl_t             ctl,
  output logic             ic_flush,
  output logic             oc_flush,
  output logic             err
);
  ctl_t ctl_q, ctl_d;
  logic err_q, err_d;
  logic any_en, dbl_req;

  assign any_en  = ctl_q.ic_en | ctl_q.oc_en;
  assign dbl_req = wdata[B_DBL];

  always_comb begin
    ctl_d = ctl_q;
    err_d = 1'b0;
    if (wr) begin
      ctl_d.ic_en  = wdata[B_IC_EN];
      ctl_d.ic_hi  = wdata[B_IC_HI];
      ctl_d.oc_en  = wdata[B_OC_EN];
      ctl_d.oc_hi  = wdata[B_OC_HI];
      ctl_d.oc_ram = wdata[B_OC_RAM];
      ctl_d.cb     = wdata[B_CB];
      if ((dbl_req != ctl_q.dbl) && any_en) err_d = 1'b1;
      else                                  ctl_d.dbl = dbl_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr) ctl_q <= ctl_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[B_IC_EN]  = ctl_q.ic_en;
    rdata[B_IC_HI]  = ctl_q.ic_hi;
    rdata[B_OC_EN]  = ctl_q.oc_en;
    rdata[B_OC_HI]  = ctl_q.oc_hi;
    rdata[B_OC_RAM] = ctl_q.oc_ram;
    rdata[B_CB]     = ctl_q.cb;
    rdata[B_DBL]    = ctl_q.dbl;
  end

  assign ctl      = ctl_q;
  assign err      = err_q;
  assign ic_flush = wr & wdata[B_IC_INV];
  assign oc_flush = wr & wdata[B_OC_INV];

  AST_DBL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |=> $stable(ctl_q.dbl)); // R9
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && (dbl_req == ctl_q.dbl) |=> !err); // R9
endmodule

// File: rtl/cachectl_index.sv
module cachectl_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int LSB    = 5,
  parameter int HI_BIT = 25
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic              hi_mode,
  output logic [IDX_W-1:0]  idx
);
  localparam int TOP_PLAIN = LSB + IDX_W - 1;
  localparam int TOP_SWAP  = LSB + IDX_W - 2;

  always_comb begin
    if (hi_mode) idx = {ea[HI_BIT], ea[TOP_SWAP:LSB]};
    else         idx = ea[TOP_PLAIN:LSB];
  end
endmodule

// File: rtl/cachectl_flags.sv
module cachectl_flags #(
  parameter int IDX_W = 8,
  parameter bit HAS_U = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_v,
  input  logic [IDX_W-1:0] set_v_idx,
  input  logic             set_u,
  input  logic [IDX_W-1:0] set_u_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_v,
  output logic             rd_u
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0] v_q, v_d;

  always_comb begin
    v_d = v_q;
    if (flush)      v_d = '0;
    else if (set_v) v_d[set_v_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               v_q <= '0;
    else if (flush || set_v)  v_q <= v_d;
  end

  assign rd_v = v_q[rd_idx];

  AST_FLUSH_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (v_q == '0)); // R4

  generate
    if (HAS_U) begin : g_use
      logic [N-1:0] u_q, u_d;

      always_comb begin
        u_d = u_q;
        if (flush)      u_d = '0;
        else if (set_u) u_d[set_u_idx] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              u_q <= '0;
        else if (flush || set_u) u_q <= u_d;
      end

      assign rd_u = u_q[rd_idx];

      AST_FLUSH_CLEARS_U: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (u_q == '0)); // R5
    end else begin : g_no_use
      assign rd_u = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cachectl_top.sv
module cachectl_top
  import cachectl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IC_IDX_W = 8,
  parameter int OC_IDX_W = 9,
  parameter int LINE_LSB = 5,
  parameter int HI_BIT   = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [ADDR_W-1:0]   ea,
  input  logic                xlat_on,
  input  logic                page_cacheable,
  input  logic                ic_fill,
  input  logic [IC_IDX_W-1:0] ic_fill_idx,
  input  logic                oc_fill,
  input  logic [OC_IDX_W-1:0] oc_fill_idx,
  input  logic                oc_touch,
  input  logic [OC_IDX_W-1:0] oc_touch_idx,
  output logic [IC_IDX_W-1:0] ic_idx,
  output logic [OC_IDX_W-1:0] oc_idx,
  output logic                ic_valid,
  output logic                oc_valid,
  output logic                oc_used,
  output logic                ic_usable,
  output logic                oc_ram_act,
  output logic                copy_back,
  output logic                dbl_size,
  output logic                proto_err
);
  logic rst_sync_n;
  ctl_t ctl;
  logic ic_flush, oc_flush;
  logic ic_u_unused;

  cachectl_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  cachectl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ctl      (ctl),
    .ic_flush (ic_flush),
    .oc_flush (oc_flush),
    .err      (proto_err)
  );

  cachectl_index #(.ADDR_W(ADDR_W), .IDX_W(IC_IDX_W), .LSB(LINE_LSB), .HI_BIT(HI_BIT))
    u_ic_idx (.ea(ea), .hi_mode(ctl.ic_hi), .idx(ic_idx));

  cachectl_index #(.ADDR_W(ADDR_W), .IDX_W(OC_IDX_W), .LSB(LINE_LSB), .HI_BIT(HI_BIT))
    u_oc_idx (.ea(ea), .hi_mode(ctl.oc_hi), .idx(oc_idx));

  cachectl_flags #(.IDX_W(IC_IDX_W), .HAS_U(1'b0)) u_ic_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (ic_flush),
    .set_v     (ic_fill),
    .set_v_idx (ic_fill_idx),
    .set_u     (1'b0),
    .set_u_idx ('0),
    .rd_idx    (ic_idx),
    .rd_v      (ic_valid),
    .rd_u      (ic_u_unused)
  );

  cachectl_flags #(.IDX_W(OC_IDX_W), .HAS_U(1'b1)) u_oc_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (oc_flush),
    .set_v     (oc_fill),
    .set_v_idx (oc_fill_idx),
    .set_u     (oc_touch),
    .set_u_idx (oc_touch_idx),
    .rd_idx    (oc_idx),
    .rd_v      (oc_valid),
    .rd_u      (oc_used)
  );

  assign ic_usable  = ctl.ic_en & (~xlat_on | page_cacheable);
  assign oc_ram_act = ctl.oc_en & ctl.oc_ram;
  assign copy_back  = ctl.cb;
  assign dbl_size   = ctl.dbl;

  AST_USABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ic_usable |-> reg_rdata[B_IC_EN]); // R6
  AST_RAM_NEEDS_OCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oc_ram_act |-> reg_rdata[B_OC_EN]); // R7
  AST_INV_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(reg_wr) |-> (reg_rdata[B_IC_INV] == 1'b0 && reg_rdata[B_OC_INV] == 1'b0)); // R4
endmodule

// File: tb/cachectl_top_tb_top.sv
module cachectl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [31:0] ea;
  logic        xlat_on, page_cacheable;
  logic        ic_fill, oc_fill, oc_touch;
  logic [7:0]  ic_fill_idx;
  logic [8:0]  oc_fill_idx, oc_touch_idx;
  logic [7:0]  ic_idx;
  logic [8:0]  oc_idx;
  logic        ic_valid, oc_valid, oc_used, ic_usable, oc_ram_act;
  logic        copy_back, dbl_size, proto_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cachectl_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ea(ea), .xlat_on(xlat_on),
    .page_cacheable(page_cacheable), .ic_fill(ic_fill), .ic_fill_idx(ic_fill_idx),
    .oc_fill(oc_fill), .oc_fill_idx(oc_fill_idx), .oc_touch(oc_touch),
    .oc_touch_idx(oc_touch_idx), .ic_idx(ic_idx), .oc_idx(oc_idx),
    .ic_valid(ic_valid), .oc_valid(oc_valid), .oc_used(oc_used),
    .ic_usable(ic_usable), .oc_ram_act(oc_ram_act), .copy_back(copy_back),
    .dbl_size(dbl_size), .proto_err(proto_err)
  );

  // {ea, ic index mode, oc index mode, expected ic_idx, expected oc_idx}
  typedef struct packed {
    logic [31:0] ea;
    logic        ic_hi;
    logic        oc_hi;
    logic [7:0]  exp_ic;
    logic [8:0]  exp_oc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1FE0, 1'b0, 1'b0, 8'hFF, 9'h0FF},
    '{32'h0200_0000, 1'b1, 1'b1, 8'h80, 9'h100},
    '{32'h0200_0000, 1'b0, 1'b0, 8'h00, 9'h000},
    '{32'h0000_3FE0, 1'b1, 1'b1, 8'h7F, 9'h0FF},
    '{32'h0000_3FE0, 1'b0, 1'b0, 8'hFF, 9'h1FF},
    '{32'h0200_1000, 1'b1, 1'b0, 8'h80, 9'h080},
    '{32'hFFFF_FFFF, 1'b0, 1'b1, 8'hFF, 9'h1FF},
    '{32'h0000_0020, 1'b0, 1'b0, 8'h01, 9'h001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; ea = '0;
    xlat_on = 1'b0; page_cacheable = 1'b0;
    ic_fill = 1'b0; oc_fill = 1'b0; oc_touch = 1'b0;
    ic_fill_idx = '0; oc_fill_idx = '0; oc_touch_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 0);
    check("R1 ic_usable", ic_usable, 0);
    check("R1 oc_ram_act", oc_ram_act, 0);
    check("R1 copy_back", copy_back, 0);
    check("R1 dbl_size", dbl_size, 0);
    check("R1 proto_err", proto_err, 0);
    check("R1 ic_valid", ic_valid, 0);
    check("R1 oc_valid", oc_valid, 0);

    // R2 R3 index vectors
    for (int i = 0; i < NV; i++) begin
      wr_reg(16'((VECS[i].ic_hi << 2) | (VECS[i].oc_hi << 5)));
      ea = VECS[i].ea;
      #1;
      check("R2 ic_idx", ic_idx, VECS[i].exp_ic);
      check("R3 oc_idx", oc_idx, VECS[i].exp_oc);
    end

    // R11 layout, invalidate bits read 0 (R4 R5)
    wr_reg(16'h01FF);
    check("R11 rdata", reg_rdata, 16'h01ED);
    check("R9 no err while disabled", proto_err, 0);
    // R9 blocked change
    wr_reg(16'h00ED);
    check("R9 dbl held", reg_rdata, 16'h01ED);
    check("R9 err pulse", proto_err, 1);
    @(negedge clk);
    check("R9 err one cycle", proto_err, 0);
    wr_reg(16'h0100);
    check("R9 disable keeps dbl", reg_rdata, 16'h0100);
    check("R9 unchanged no err", proto_err, 0);
    wr_reg(16'h0000);
    check("R9 dbl cleared", dbl_size, 0);
    check("R9 no err after clear", proto_err, 0);

    // R6
    wr_reg(16'h0001);
    xlat_on = 0; page_cacheable = 0; #1;
    check("R6 no xlat", ic_usable, 1);
    xlat_on = 1; #1;
    check("R6 xlat page uncached", ic_usable, 0);
    page_cacheable = 1; #1;
    check("R6 xlat page cached", ic_usable, 1);
    wr_reg(16'h0000); #1;
    check("R6 disabled", ic_usable, 0);
    xlat_on = 0; page_cacheable = 0;

    // R7 R8
    wr_reg(16'h0048);
    check("R7 ram active", oc_ram_act, 1);
    wr_reg(16'h0040);
    check("R7 ram needs oce", oc_ram_act, 0);
    wr_reg(16'h0080);
    check("R8 copy-back", copy_back, 1);
    wr_reg(16'h0000);
    check("R8 write-through", copy_back, 0);

    // R10 / R4 instruction flags
    ea = 32'h0000_00A0;
    @(negedge clk); ic_fill = 1; ic_fill_idx = 8'd5;
    @(negedge clk); ic_fill = 0;
    check("R10 ic fill", ic_valid, 1);
    wr_reg(16'h0002);
    check("R4 ic flush", ic_valid, 0);
    @(negedge clk); ic_fill = 1; reg_wr = 1; reg_wdata = 16'h0002;
    @(negedge clk); ic_fill = 0; reg_wr = 0; reg_wdata = 0;
    check("R10 flush beats fill", ic_valid, 0);

    // R5 operand flags
    ea = 32'h0000_00E0;
    @(negedge clk); oc_fill = 1; oc_fill_idx = 9'd7; oc_touch = 1; oc_touch_idx = 9'd7;
    @(negedge clk); oc_fill = 0; oc_touch = 0;
    check("R10 oc fill", oc_valid, 1);
    check("R10 oc touch", oc_used, 1);
    wr_reg(16'h0002);
    check("R4 ic flush leaves oc v", oc_valid, 1);
    check("R4 ic flush leaves oc u", oc_used, 1);
    wr_reg(16'h0010);
    check("R5 oc v cleared", oc_valid, 0);
    check("R5 oc u cleared", oc_used, 0);
    check("R5 reads zero", reg_rdata, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule